// File: doc/BRIEF.md
# Packed Lane Shifter with Rounding and Saturation

This block shifts every lane of a 32-bit packed word by the same amount in one pass. A word holds either four 8-bit lanes or two 16-bit lanes. The lane width follows the register bank that the instruction names. Three kinds of shift are offered: arithmetic right, logical right and left. The shift amount comes either from the low bits of a second source register or from the instruction's immediate field.

A 2-bit mode field sets how the shift treats the edges of the result. One mode forces the special behaviour for a single instruction: right shifts round and left shifts saturate. The other modes follow a global rounding/saturation setting. The result is registered and comes out one cycle after a valid input, together with a matching valid flag.

Top module: `packed_lane_shifter`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid` and `out_data` become 0.
- R2: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_data` changes only after a valid input and otherwise holds its value.
- R3: With `lane16` = 0 the word is four independent 8-bit lanes. This is the bank of specifiers 2 to 15. With `lane16` = 1 it is two independent 16-bit lanes, the bank of specifiers 16 to 29. No lane's result depends on another lane.
- R4: With `imm_sel` = 1 the amount is `imm_amt`. With `imm_sel` = 0 it is `rs_amt`. Only the low 3 bits count for 8-bit lanes and the low 4 bits for 16-bit lanes.
- R5: `shift_kind` encoding: 2'b00 arithmetic right, 2'b01 logical right, 2'b10 left, 2'b11 reserved. The reserved code returns the operand unchanged.
- R6: An arithmetic right shift without rounding fills each lane with copies of its sign bit.
- R7: A logical right shift without rounding fills each lane with zeros.
- R8: A left shift without saturation fills with zeros and drops the bits shifted out of the lane.
- R9: Rounding/saturation is enabled when `mode` = 2'b01. For `mode` 2'b00, 2'b10 and 2'b11 it is enabled exactly when `global_rs` = 1.
- R10: When enabled, a right shift by s > 0 adds the last bit shifted out, bit s-1 of the lane, to the truncated lane result. A shift of 0 returns the lane unchanged and is never rounded.
- R11: When enabled, a left shift whose exact signed result falls outside the lane's signed range gives the lane's signed maximum (lane sign 0) or signed minimum (lane sign 1). Otherwise it gives the plain result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input operation is valid this cycle |
| lane16 | input | 1 | Bank bit of the register specifier: 0 gives 8-bit lanes, 1 gives 16-bit lanes |
| operand | input | 32 | Packed data word to shift |
| rs_amt | input | 4 | Low four bits of the second source register |
| imm_amt | input | 4 | Low four bits of the instruction immediate |
| imm_sel | input | 1 | 1 selects the immediate amount, 0 the register amount |
| shift_kind | input | 2 | Shift kind code (see R5) |
| mode | input | 2 | Per-instruction rounding/saturation mode (see R9) |
| global_rs | input | 1 | Global rounding/saturation enable |
| out_valid | output | 1 | `out_data` carries a new result |
| out_data | output | 32 | Registered shifted word |

## Verification
Some properties are checked on every cycle. The valid flag tracks the input one cycle later, and the output word holds when no input arrives. A zero effective amount passes the operand through for every kind and mode. A plain arithmetic right shift keeps each 16-bit lane's sign. A plain logical right shift of 8-bit lanes never makes a lane larger. The bench scenarios are needed for the rest: the exact rounded values, the clamp points of saturation, the choice between immediate and register amount, and the effect of the mode/global combinations. These are compared against a lane-by-lane integer model over random and directed operands.

// File: rtl/pls_pkg.sv
// Package: shared codes for the packed lane shifter.
// Assumes a 32-bit data word split into 8-bit or 16-bit lanes.
package pls_pkg;
    localparam int WORD_W = 32;
    localparam int NARROW_W = 8;
    localparam int WIDE_W = 16;
    localparam int NARROW_N = WORD_W / NARROW_W;
    localparam int WIDE_N = WORD_W / WIDE_W;
    localparam int NARROW_SW = $clog2(NARROW_W);
    localparam int WIDE_SW = $clog2(WIDE_W);

    typedef enum logic [1:0] {
        SK_ARITH_R = 2'b00,
        SK_LOGIC_R = 2'b01,
        SK_LEFT    = 2'b10,
        SK_RSVD    = 2'b11
    } shift_kind_e;
endpackage

// File: rtl/pls_ctrl.sv
// Control decode: picks the shift amount source, trims it to each lane
// width and resolves the rounding/saturation enable from mode and global.
// Assumes amounts wider than the lane are taken modulo the lane width.
module pls_ctrl
    import pls_pkg::*;
(
    input  logic                 imm_sel,
    input  logic [WIDE_SW-1:0]   rs_amt,
    input  logic [WIDE_SW-1:0]   imm_amt,
    input  logic [1:0]           mode,
    input  logic                 global_rs,
    output logic [NARROW_SW-1:0] amt_n,
    output logic [WIDE_SW-1:0]   amt_w,
    output logic                 rs_en
);
    logic [WIDE_SW-1:0] amt_sel;

    // Choose the amount source and trim it per lane width.
    always_comb begin
        amt_sel = imm_sel ? imm_amt : rs_amt;
        amt_n   = amt_sel[NARROW_SW-1:0];
        amt_w   = amt_sel;
    end

    // Mode 01 forces the edge behaviour; other modes defer to the global bit.
    always_comb begin
        rs_en = (mode == 2'b01) || global_rs;
    end
endmodule

// File: rtl/pls_lane.sv
// One lane of the shifter: arithmetic/logical right with optional rounding,
// left with optional signed saturation, reserved kind passes through.
// Assumes sh < W (guaranteed by the amount trim in pls_ctrl).
module pls_lane
    import pls_pkg::*;
#(
    parameter int W  = 8,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  a,
    input  logic [SW-1:0] sh,
    input  shift_kind_e   kind,
    input  logic          rs_en,
    output logic [W-1:0]  y
);
    localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

    logic [SW-1:0] sh_m1;
    logic          last_out;
    logic [W-1:0]  rnd_inc;
    logic [W-1:0]  sra_t;
    logic [W-1:0]  srl_t;
    logic [W-1:0]  shl_t;
    logic [W-1:0]  shl_back;
    logic          shl_ovf;

    // Raw shift results and the bit that leaves last on a right shift.
    always_comb begin
        sh_m1    = sh - 1'b1;
        last_out = (sh != '0) && a[sh_m1];
        rnd_inc  = {{(W-1){1'b0}}, (rs_en && last_out)};
        sra_t    = $signed(a) >>> sh;
        srl_t    = a >> sh;
        shl_t    = a << sh;
        shl_back = $signed(shl_t) >>> sh;
        shl_ovf  = (shl_back != a);
    end

    // Final lane value per shift kind.
    always_comb begin
        unique case (kind)
            SK_ARITH_R: y = sra_t + rnd_inc;
            SK_LOGIC_R: y = srl_t + rnd_inc;
            SK_LEFT:    y = (rs_en && shl_ovf) ? (a[W-1] ? SMIN : SMAX) : shl_t;
            default:    y = a;
        endcase
    end
endmodule

// File: rtl/packed_lane_shifter.sv
// Top: packed 8/16-bit lane shifter with a one-cycle registered result.
// Assumes lane16 comes from the bank bit of the register specifier and
// that in_valid is low while rst_n is low.
module packed_lane_shifter
    import pls_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        lane16,
    input  logic [31:0] operand,
    input  logic [3:0]  rs_amt,
    input  logic [3:0]  imm_amt,
    input  logic        imm_sel,
    input  logic [1:0]  shift_kind,
    input  logic [1:0]  mode,
    input  logic        global_rs,
    output logic        out_valid,
    output logic [31:0] out_data
);
    logic [NARROW_SW-1:0] amt_n;
    logic [WIDE_SW-1:0]   amt_w;
    logic                 rs_en;
    shift_kind_e          kind;
    logic [WORD_W-1:0]    res_n;
    logic [WORD_W-1:0]    res_w;
    logic [WORD_W-1:0]    res;

    assign kind = shift_kind_e'(shift_kind);

    pls_ctrl u_ctrl (
        .imm_sel   (imm_sel),
        .rs_amt    (rs_amt),
        .imm_amt   (imm_amt),
        .mode      (mode),
        .global_rs (global_rs),
        .amt_n     (amt_n),
        .amt_w     (amt_w),
        .rs_en     (rs_en)
    );

    // Four narrow lanes and two wide lanes computed side by side.
    for (genvar g = 0; g < NARROW_N; g++) begin : g_narrow
        pls_lane #(.W(NARROW_W), .SW(NARROW_SW)) u_lane (
            .a     (operand[g*NARROW_W +: NARROW_W]),
            .sh    (amt_n),
            .kind  (kind),
            .rs_en (rs_en),
            .y     (res_n[g*NARROW_W +: NARROW_W])
        );
    end

    for (genvar g = 0; g < WIDE_N; g++) begin : g_wide
        pls_lane #(.W(WIDE_W), .SW(WIDE_SW)) u_lane (
            .a     (operand[g*WIDE_W +: WIDE_W]),
            .sh    (amt_w),
            .kind  (kind),
            .rs_en (rs_en),
            .y     (res_w[g*WIDE_W +: WIDE_W])
        );
    end

    // Select the lane layout named by the register bank.
    always_comb begin
        res = lane16 ? res_w : res_n;
    end

    // Output register: capture on valid input, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= res;
            end
        end
    end

    // Valid follows the input by one cycle.
    p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // Data holds when no input arrives.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data));
    // A zero effective amount passes the operand through unchanged.
    p_zero_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind != SK_RSVD && (lane16 ? (amt_w == '0) : (amt_n == '0)))
        |=> out_data == $past(operand));
    // Plain arithmetic right shift keeps the sign of each wide lane.
    p_sign_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && lane16 && kind == SK_ARITH_R && !rs_en)
        |=> (out_data[15] == $past(operand[15])) && (out_data[31] == $past(operand[31])));
    // Plain logical right shift never grows a narrow lane.
    p_no_grow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !lane16 && kind == SK_LOGIC_R && !rs_en)
        |=> (out_data[7:0]   <= $past(operand[7:0]))   &&
            (out_data[15:8]  <= $past(operand[15:8]))  &&
            (out_data[23:16] <= $past(operand[23:16])) &&
            (out_data[31:24] <= $past(operand[31:24])));
    // Reserved kind returns the operand.
    p_rsvd_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == SK_RSVD) |=> out_data == $past(operand));
endmodule

// File: tb/sim_packed_lane_shifter.sv
// Bench: directed corners plus seeded random operations checked against
// an integer lane model written from the requirements.
module sim_packed_lane_shifter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        lane16 = 1'b0;
    logic [31:0] operand = '0;
    logic [3:0]  rs_amt = '0;
    logic [3:0]  imm_amt = '0;
    logic        imm_sel = 1'b0;
    logic [1:0]  shift_kind = '0;
    logic [1:0]  mode = '0;
    logic        global_rs = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    packed_lane_shifter u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .lane16(lane16),
        .operand(operand), .rs_amt(rs_amt), .imm_amt(imm_amt), .imm_sel(imm_sel),
        .shift_kind(shift_kind), .mode(mode), .global_rs(global_rs),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #10 clk = ~clk;

    // Model of one lane, integer arithmetic (R6, R7, R8, R10, R11, R5).
    function automatic int lane_model(int a, int w, int s, int kind, bit en);
        int mask = (1 << w) - 1;
        int sa = (a >= (1 << (w - 1))) ? a - (1 << w) : a;
        int r;
        int full;
        case (kind)
            0: begin
                r = sa >>> s;
                if (en && s > 0) r = r + ((a >> (s - 1)) & 1);
            end
            1: begin
                r = a >> s;
                if (en && s > 0) r = r + ((a >> (s - 1)) & 1);
            end
            2: begin
                if (en) begin
                    full = sa * (1 << s);
                    if (full > (1 << (w - 1)) - 1) r = (1 << (w - 1)) - 1;
                    else if (full < -(1 << (w - 1))) r = -(1 << (w - 1));
                    else r = full;
                end else begin
                    r = a << s;
                end
            end
            default: r = a;
        endcase
        return r & mask;
    endfunction

    // Whole-word model: lane split (R3), amount source (R4), enable (R9).
    function automatic logic [31:0] word_model(logic [31:0] op, bit l16, logic [3:0] ra,
                                               logic [3:0] ia, bit isel, int kind,
                                               logic [1:0] md, bit g);
        int w = l16 ? 16 : 8;
        int amt = isel ? int'(ia) : int'(ra);
        int s = amt % w;
        bit en = (md == 2'b01) || g;
        logic [31:0] res = '0;
        for (int i = 0; i < 32 / w; i++) begin
            int a = int'((op >> (i * w)) & ((32'd1 << w) - 1));
            res = res | (32'(lane_model(a, w, s, kind, en)) << (i * w));
        end
        return res;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one operation, then sample the registered result one cycle later.
    task automatic run_op(string tag, logic [31:0] op, bit l16, logic [3:0] ra,
                          logic [3:0] ia, bit isel, logic [1:0] kind,
                          logic [1:0] md, bit g, logic [31:0] exp);
        @(negedge clk);
        in_valid = 1'b1; operand = op; lane16 = l16; rs_amt = ra; imm_amt = ia;
        imm_sel = isel; shift_kind = kind; mode = md; global_rs = g;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, out_data, exp);
        check({tag, " valid R2"}, {31'd0, out_valid}, 32'd1);
    endtask

    task automatic run_model(string tag, logic [31:0] op, bit l16, logic [3:0] ra,
                             logic [3:0] ia, bit isel, logic [1:0] kind,
                             logic [1:0] md, bit g);
        run_op(tag, op, l16, ra, ia, isel, kind, md, g,
               word_model(op, l16, ra, ia, isel, int'(kind), md, g));
    endtask

    initial begin
        int seed = 32'h5eed_1234;
        logic [31:0] held;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 reset data", out_data, 32'd0);
        check("R1 reset valid", {31'd0, out_valid}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: plain arithmetic right on narrow lanes
        run_op("R6 sra8", 32'h80_7F_F0_10, 1'b0, 4'd3, 4'd0, 1'b0, 2'b00, 2'b00, 1'b0, 32'hF0_0F_FE_02);
        // R7: plain logical right on wide lanes
        run_op("R7 srl16", 32'h8000_FFFF, 1'b1, 4'd4, 4'd0, 1'b0, 2'b01, 2'b00, 1'b0, 32'h0800_0FFF);
        // R8: plain left wraps
        run_op("R8 sll8", 32'hC3_81_01_FF, 1'b0, 4'd1, 4'd0, 1'b0, 2'b10, 2'b00, 1'b0, 32'h86_02_02_FE);
        // R10: rounding right shift, mode forced
        run_op("R10 sra8 round", 32'h07_05_FF_FB, 1'b0, 4'd1, 4'd0, 1'b0, 2'b00, 2'b01, 1'b0, 32'h04_03_00_FE);
        run_op("R10 srl16 round", 32'h0003_FFFF, 1'b1, 4'd1, 4'd0, 1'b0, 2'b01, 2'b01, 1'b0, 32'h0002_8000);
        // R10: zero shift not rounded
        run_op("R10 zero shift", 32'h7F_FF_01_80, 1'b0, 4'd0, 4'd0, 1'b0, 2'b00, 2'b01, 1'b0, 32'h7F_FF_01_80);
        // R11: saturating left shifts
        run_op("R11 sat16", 32'h4000_8001, 1'b1, 4'd1, 4'd0, 1'b0, 2'b10, 2'b01, 1'b0, 32'h7FFF_8000);
        run_op("R11 sat8 inrange", 32'h1F_E0_40_C0, 1'b0, 4'd1, 4'd0, 1'b0, 2'b10, 2'b01, 1'b0, 32'h3E_C0_7F_80);
        // R9: mode 10 follows global (off then on)
        run_op("R9 global off", 32'h0000_0003, 1'b1, 4'd1, 4'd0, 1'b0, 2'b01, 2'b10, 1'b0, 32'h0000_0001);
        run_op("R9 global on", 32'h0000_0003, 1'b1, 4'd1, 4'd0, 1'b0, 2'b01, 2'b10, 1'b1, 32'h0000_0002);
        // R4: immediate vs register amount; amount trimmed to 3 bits for bytes
        run_op("R4 imm sel", 32'h0000_0100, 1'b1, 4'd1, 4'd8, 1'b1, 2'b01, 2'b00, 1'b0, 32'h0000_0001);
        run_op("R4 reg sel", 32'h0000_0100, 1'b1, 4'd1, 4'd8, 1'b0, 2'b01, 2'b00, 1'b0, 32'h0000_0080);
        run_op("R4 trim8", 32'h40_40_40_40, 1'b0, 4'd9, 4'd0, 1'b0, 2'b01, 2'b00, 1'b0, 32'h20_20_20_20);
        // R3: lanes independent, same word gives different results per width
        run_op("R3 lanes8", 32'h0180_0180, 1'b0, 4'd1, 4'd0, 1'b0, 2'b00, 2'b00, 1'b0, 32'h00C0_00C0);
        run_op("R3 lanes16", 32'h0180_0180, 1'b1, 4'd1, 4'd0, 1'b0, 2'b00, 2'b00, 1'b0, 32'h00C0_00C0);
        run_op("R3 lanes16 cross", 32'h0100_0100, 1'b1, 4'd1, 4'd0, 1'b0, 2'b00, 2'b00, 1'b0, 32'h0080_0080);
        run_op("R3 lanes8 cross", 32'h0100_0100, 1'b0, 4'd1, 4'd0, 1'b0, 2'b00, 2'b00, 1'b0, 32'h0000_0000);
        // R5: reserved kind passes operand
        run_op("R5 reserved", 32'hDEAD_BEEF, 1'b0, 4'd3, 4'd0, 1'b0, 2'b11, 2'b01, 1'b1, 32'hDEAD_BEEF);

        // R2: output holds while idle even though inputs change
        held = out_data;
        @(negedge clk);
        operand = 32'h1234_5678; shift_kind = 2'b10; rs_amt = 4'd2;
        @(negedge clk);
        check("R2 hold data", out_data, held);
        check("R2 idle valid", {31'd0, out_valid}, 32'd0);

        // Random mix over all requirements R3..R11
        for (int i = 0; i < 400; i++) begin
            run_model("R3-mix random", $urandom, 1'($urandom), 4'($urandom), 4'($urandom),
                      1'($urandom), 2'($urandom), 2'($urandom), 1'($urandom));
        end
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule